// File: doc/BRIEF.md
# Coherent Split-Byte Converter Result Register

This block stores the output of a 10-bit converter and lets an 8-bit bus read it as two bytes. When software reads the upper byte in 10-bit mode, the lower byte of that same result is frozen. A later lower-byte read then returns data from that conversion, even if newer conversions have finished in the meantime. Results that arrive while the pair is frozen wait in a single pending register. The lower-byte read that ends the freeze moves the pending result into the visible pair.

A simple freeze latch only starts to hold one clock after the upper-byte read. That leaves one cycle in which a conversion that finishes on the same clock as the upper-byte read can overwrite the low byte. This design treats the upper-byte read cycle as already frozen, so that conversion goes to the pending register and the returned byte pair stays coherent.

In 8-bit mode the result is reduced to its eight most significant bits and read from the low address. Conversions update it directly and the freeze is never used. A completion flag reports that an unread result exists. An overrun flag reports that a pending result was replaced before it could be read.

Top module: `adc_result_reg`

## Requirements
- R1: A synchronous reset, active while `rst_n` is low at a clock edge, clears the visible result, the pending result, the freeze state, `conv_flag` and `ovr_flag`. A conversion that arrives right after reset is captured directly, because no freeze survives the reset.
- R2: Read data is combinational and valid in the same cycle as `rd_en`, and it is 0 when `rd_en` is low.
  - In 10-bit mode (`mode_10b`=1), `rd_addr`=1 selects the high byte, which is the result's bits 9:8 right-justified with bits 7:2 read as zero.
  - `rd_addr`=0 selects the low byte, which is result bits 7:0.
- R3: A high-byte read in 10-bit mode freezes the visible result from the next clock. Until a low-byte read, no conversion changes the visible result.
- R4: A conversion that completes on the same clock as a high-byte read in 10-bit mode goes to the pending register. The low byte returned by the next low-byte read comes from the conversion that the high byte was read from.
- R5: A low-byte read while frozen releases the freeze on that clock edge. A conversion completing on that same clock becomes visible. Otherwise a pending result becomes visible. With neither, the visible result stays as it was.
- R6: Only the most recent pending result is kept. `ovr_flag` sets when a conversion completes while a pending result already waits in the frozen state. It clears on the next high-byte read in 10-bit mode, and a coincident set wins.
- R7: `conv_flag` sets on every completed conversion and on promotion of a pending result. It clears on a low-address read in either mode, and a coincident set wins.
- R8: In 8-bit mode (`mode_10b`=0), `rd_addr`=0 returns result bits 9:2 and `rd_addr`=1 returns 0. Conversions update the result directly, and the freeze and pending state are cleared.
- R9: With no new conversion, repeated high and low reads of one result return the same bytes every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe: conversion complete |
| conv_data | input | 10 | Result accompanying `conv_done` |
| mode_10b | input | 1 | 1 = 10-bit results, 0 = 8-bit results |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 1 | 1 = high byte, 0 = low byte |
| rd_data | output | 8 | Byte returned for the read |
| conv_flag | output | 1 | Unread result available |
| ovr_flag | output | 1 | A pending result was replaced |

## Verification
Assertions check on every cycle the properties that relate to single clock edges:
- the visible result holds through the race cycle and throughout a freeze;
- a high-byte read always sets the freeze;
- 8-bit mode never freezes;
- each flag follows its set and clear events;
- unused high-byte bits and idle read data are zero.

Only the bench scenarios show the byte values returned across whole read sequences. These include the coherent low byte after the race, which result a release promotes, the loss of an older pending result, and the recovery after reset.

// File: rtl/adc_res_pkg.sv
// Package adc_res_pkg
// Shared constants for the split-byte converter result register.
// Assumes a one-bit byte address: 0 selects the low byte, 1 the high byte.
package adc_res_pkg;
    localparam logic ADDR_LO = 1'b0;
    localparam logic ADDR_HI = 1'b1;

    typedef enum logic {
        MODE_8B  = 1'b0,
        MODE_10B = 1'b1
    } res_mode_e;
endpackage

// File: rtl/adc_res_capture.sv
// Module adc_res_capture
// Holds the visible result, the pending result and the freeze state.
// Treats the cycle of a high-byte read as already frozen, so that a
// conversion completing on that clock goes to the pending register.
// Assumes rd_hi and rd_lo are never high together.
module adc_res_capture #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic             mode_10b,
    input  logic             rd_hi,
    input  logic             rd_lo,
    output logic [RES_W-1:0] res_q,
    output logic             pend_v_q,
    output logic             frozen_eff,
    output logic             promote
);
    logic [RES_W-1:0] pend_q;
    logic             frozen_q;
    logic             release_now;

    // Decide whether this cycle counts as frozen and whether a release happens.
    always_comb begin
        frozen_eff  = mode_10b && (frozen_q || rd_hi);
        release_now = mode_10b && frozen_q && rd_lo;
        promote     = release_now && pend_v_q && !conv_done;
    end

    // Update the visible result, the pending result and the freeze state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            frozen_q <= 1'b0;
        end else if (!mode_10b) begin
            frozen_q <= 1'b0;
            pend_v_q <= 1'b0;
            if (conv_done) res_q <= conv_data;
        end else if (release_now) begin
            frozen_q <= 1'b0;
            pend_v_q <= 1'b0;
            if (conv_done)     res_q <= conv_data;
            else if (pend_v_q) res_q <= pend_q;
        end else begin
            if (rd_hi) frozen_q <= 1'b1;
            if (conv_done) begin
                if (frozen_eff) begin
                    pend_q   <= conv_data;
                    pend_v_q <= 1'b1;
                end else begin
                    res_q <= conv_data;
                end
            end
        end
    end

    AST_RACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && mode_10b && conv_done) |=> (res_q == $past(res_q))); // R4
    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && mode_10b && !rd_lo) |=> (res_q == $past(res_q))); // R3
    AST_FREEZE_ON_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && mode_10b) |=> frozen_q); // R3
    AST_NO_FREEZE_8B: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_10b) |=> (!frozen_q && !pend_v_q)); // R8
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && mode_10b) |=> !frozen_q); // R5
endmodule

// File: rtl/adc_res_flags.sv
// Module adc_res_flags
// Maintains the completion flag and the overrun flag.
// In both flags a set on the same clock as a clear wins.
module adc_res_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_done,
    input  logic mode_10b,
    input  logic rd_hi,
    input  logic rd_lo,
    input  logic frozen_eff,
    input  logic pend_v,
    input  logic promote,
    output logic conv_flag,
    output logic ovr_flag
);
    logic cf_set;
    logic ov_set;

    // Derive the set events of both flags.
    always_comb begin
        cf_set = conv_done || promote;
        ov_set = conv_done && frozen_eff && pend_v;
    end

    // Apply set-over-clear priority to both flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_flag <= 1'b0;
            ovr_flag  <= 1'b0;
        end else begin
            if (cf_set)     conv_flag <= 1'b1;
            else if (rd_lo) conv_flag <= 1'b0;
            if (ov_set)                   ovr_flag <= 1'b1;
            else if (rd_hi && mode_10b)   ovr_flag <= 1'b0;
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> conv_flag); // R7
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !conv_done && !promote) |=> !conv_flag); // R7
    AST_OVR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && mode_10b && !conv_done) |=> !ovr_flag); // R6
endmodule

// File: rtl/adc_res_readmux.sv
// Module adc_res_readmux
// Selects the byte returned for a read according to the mode and the address.
// The output is combinational and 0 when no read is in progress.
module adc_res_readmux #(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] res_q,
    input  logic             mode_10b,
    input  logic             rd_en,
    input  logic             rd_addr,
    output logic [BUS_W-1:0] rd_data
);
    import adc_res_pkg::*;
    localparam int HI_W = RES_W - BUS_W;

    logic [BUS_W-1:0] hi_byte;
    logic [BUS_W-1:0] lo_byte;
    logic [BUS_W-1:0] short_byte;

    // Form the three candidate bytes from the visible result.
    always_comb begin
        hi_byte    = {{(BUS_W-HI_W){1'b0}}, res_q[RES_W-1:BUS_W]};
        lo_byte    = res_q[BUS_W-1:0];
        short_byte = res_q[RES_W-1 -: BUS_W];
    end

    // Pick the byte selected by the read.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (mode_10b) rd_data = (rd_addr == ADDR_HI) ? hi_byte : lo_byte;
            else          rd_data = (rd_addr == ADDR_HI) ? '0 : short_byte;
        end
    end

    AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_HI) |-> (rd_data[BUS_W-1:HI_W] == '0)); // R2
    AST_HI8_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_HI && !mode_10b) |-> (rd_data == '0)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |-> (rd_data == '0)); // R2
endmodule

// File: rtl/adc_result_reg.sv
// Module adc_result_reg
// Coherent split-byte result register for a converter on an 8-bit bus.
// Decodes the read strobes and connects the capture, flag and read-mux parts.
// Assumes conv_done is a one-cycle strobe in the bus clock domain and that
// mode_10b is a static configuration input.
module adc_result_reg #(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic             mode_10b,
    input  logic             rd_en,
    input  logic             rd_addr,
    output logic [BUS_W-1:0] rd_data,
    output logic             conv_flag,
    output logic             ovr_flag
);
    import adc_res_pkg::*;

    logic             rd_hi;
    logic             rd_lo;
    logic [RES_W-1:0] res_q;
    logic             pend_v_q;
    logic             frozen_eff;
    logic             promote;

    // Turn the read strobe and the address into high and low read events.
    always_comb begin
        rd_hi = rd_en && (rd_addr == ADDR_HI);
        rd_lo = rd_en && (rd_addr == ADDR_LO);
    end

    adc_res_capture #(.RES_W(RES_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .mode_10b   (mode_10b),
        .rd_hi      (rd_hi),
        .rd_lo      (rd_lo),
        .res_q      (res_q),
        .pend_v_q   (pend_v_q),
        .frozen_eff (frozen_eff),
        .promote    (promote)
    );

    adc_res_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_done  (conv_done),
        .mode_10b   (mode_10b),
        .rd_hi      (rd_hi),
        .rd_lo      (rd_lo),
        .frozen_eff (frozen_eff),
        .pend_v     (pend_v_q),
        .promote    (promote),
        .conv_flag  (conv_flag),
        .ovr_flag   (ovr_flag)
    );

    adc_res_readmux #(.RES_W(RES_W), .BUS_W(BUS_W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_q    (res_q),
        .mode_10b (mode_10b),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/tb_adc_result_reg.sv
// Bench for adc_result_reg: a vector table walked by one loop, then directed tests.
module tb_adc_result_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic       mode_10b = 1'b1;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       conv_flag;
    logic       ovr_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    adc_result_reg dut (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .mode_10b(mode_10b), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .conv_flag(conv_flag), .ovr_flag(ovr_flag)
    );

    // Vector layout: cd | data[9:0] | m10 | re | ra | exp_data[7:0] | exp_cf | exp_ov
    localparam int NV = 18;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 10'h2A5, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // 0  capture
        {1'b0, 10'h000, 1'b1, 1'b1, 1'b1, 8'h02, 1'b1, 1'b0}, // 1  high read, freeze
        {1'b1, 10'h13C, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // 2  goes pending
        {1'b0, 10'h000, 1'b1, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b0}, // 3  frozen low, release
        {1'b1, 10'h3FF, 1'b1, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0}, // 4  race cycle
        {1'b0, 10'h000, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0}, // 5  coherent low
        {1'b0, 10'h000, 1'b1, 1'b1, 1'b1, 8'h03, 1'b1, 1'b0}, // 6  promoted high
        {1'b1, 10'h001, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // 7  pending
        {1'b1, 10'h155, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // 8  overrun
        {1'b0, 10'h000, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1}, // 9  low, latest promoted
        {1'b0, 10'h000, 1'b1, 1'b1, 1'b1, 8'h01, 1'b1, 1'b1}, // 10 high clears overrun
        {1'b0, 10'h000, 1'b1, 1'b1, 1'b0, 8'h55, 1'b1, 1'b0}, // 11 release empty
        {1'b0, 10'h000, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // 12 flag cleared
        {1'b0, 10'h000, 1'b0, 1'b1, 1'b0, 8'h55, 1'b0, 1'b0}, // 13 8-bit read
        {1'b1, 10'h2C8, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0}, // 14 8-bit high is 0
        {1'b1, 10'h0F0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // 15 no freeze
        {1'b0, 10'h000, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0}, // 16 direct update
        {1'b0, 10'h000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}  // 17 flag cleared
    };

    function automatic string vec_req(int i);
        case (i)
            0, 12, 17:   return "R7";
            1, 6:        return "R3";
            2, 3, 11:    return "R5";
            4, 5:        return "R4";
            7, 8, 9, 10: return "R6";
            default:     return "R8";
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, then wait 1 ns so outputs can be sampled.
    task automatic drive(logic cd, logic [9:0] d, logic m, logic re, logic ra);
        @(negedge clk);
        conv_done = cd; conv_data = d; mode_10b = m; rd_en = re; rd_addr = ra;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state right after reset
        drive(0, 0, 1, 1, 0);
        check("R1", "reset low byte", rd_data, 0);
        check("R1", "reset conv_flag", conv_flag, 0);
        check("R1", "reset ovr_flag", ovr_flag, 0);
        drive(0, 0, 1, 0, 0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][23], VEC[i][22:13], VEC[i][12], VEC[i][11], VEC[i][10]);
            check(vec_req(i), $sformatf("vec %0d data", i), rd_data, VEC[i][9:2]);
            check("R7", $sformatf("vec %0d conv_flag", i), conv_flag, VEC[i][1]);
            check("R6", $sformatf("vec %0d ovr_flag", i), ovr_flag, VEC[i][0]);
        end

        // R1: reset during a freeze with a pending result and overrun
        drive(1, 10'h123, 1, 0, 0);
        drive(0, 0, 1, 1, 1);
        drive(1, 10'h0AA, 1, 0, 0);
        drive(1, 10'h0BB, 1, 0, 0);
        drive(0, 0, 1, 0, 0);
        rst_n = 1'b0;
        drive(0, 0, 1, 0, 0);
        rst_n = 1'b1;
        drive(1, 10'h2E7, 1, 1, 1);
        check("R1", "high after reset", rd_data, 0);
        check("R1", "conv_flag after reset", conv_flag, 0);
        check("R1", "ovr_flag after reset", ovr_flag, 0);
        // This high read froze the pair, so 0x2E7 went to pending.
        drive(0, 0, 1, 1, 0);
        check("R1", "low after reset", rd_data, 0);
        drive(0, 0, 1, 1, 0);
        check("R1", "promoted low", rd_data, 8'hE7);
        // R1: with no freeze left, a conversion is captured directly
        drive(1, 10'h1D2, 1, 0, 0);
        drive(0, 0, 1, 1, 0);
        check("R1", "direct capture", rd_data, 8'hD2);

        // R5: a conversion coincident with the release beats the pending one
        drive(0, 0, 1, 1, 1);
        check("R5", "high before race", rd_data, 8'h01);
        drive(1, 10'h111, 1, 0, 0);
        drive(1, 10'h2C4, 1, 1, 0);
        check("R5", "low at release", rd_data, 8'hD2);
        drive(0, 0, 1, 1, 1);
        check("R5", "high after release", rd_data, 8'h02);
        check("R6", "ovr on dropped pending", ovr_flag, 1);
        drive(0, 0, 1, 1, 0);
        check("R5", "low after release", rd_data, 8'hC4);

        // R9: repeated reads of one result without new conversions
        drive(1, 10'h3A9, 1, 0, 0);
        for (int k = 0; k < 2; k++) begin
            drive(0, 0, 1, 1, 1);
            check("R9", "repeat high", rd_data, 8'h03);
            drive(0, 0, 1, 1, 0);
            check("R9", "repeat low", rd_data, 8'hA9);
        end
        drive(0, 0, 1, 0, 0);
        check("R2", "idle data", rd_data, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule